// File: doc/BRIEF.md
# Page access permission evaluator

This combinational unit decides whether one memory access may go ahead once the matching segment entry and the page table entry are known. The caller supplies the page entry's rights word, the segment's attribute word, the privilege level, a 64-bit class-key mask register with its enable, the access kind and the two relocation enables. The unit returns the read, write and execute rights, a grant flag and, on a refusal, a 32-bit fault syndrome. The syndrome separates page-protection refusals from class-key refusals.

Rights come from two sources. The first is a 3-bit page-protection code read through a key bit, which is picked from the segment word by privilege. The second is a 2-bit pair taken from the mask register at a position set by a 5-bit class key in the page entry. The access is allowed only where both sources allow it. When relocation is off for the access kind, the unit bypasses all of this and returns the real address directly. It also refuses instruction fetches from no-execute segments, before any page rights are considered. Table walking, referenced and changed bit updates and interrupt delivery are left to the surrounding logic.

Top module: `pageAccessEval`

## Requirements
- R1: The key bit is segWord[10] (user key) when probState is 1 and segWord[11] (supervisor key) when probState is 0.
- R2: The protection code is {pteWord[63], pteWord[1:0]}, with pteWord[63] as its most significant bit.
- R3: With key 0, codes 0, 1 and 2 give read and write, codes 3 and 6 give read only, and codes 4, 5 and 7 give nothing.
- R4: With key 1, code 2 gives read and write, codes 1 and 3 give read only, and codes 0, 4, 5, 6 and 7 give nothing.
- R5: Execute is refused when pteWord[2] (no-execute), pteWord[3] (guarded) or segWord[9] (segment no-execute) is set, and is allowed otherwise.
- R6: The class key is pteWord[13:9]. When maskEnable is 1, bit 2*(31-key)+1 of maskReg gates write and bit 2*(31-key) gates read. Execute is never gated by the mask. When maskEnable is 0 the mask gates nothing. The rights outputs are the AND of the page rights and the mask rights.
- R7: accType encodes 0 as read, 1 as write, 2 as fetch and 3 as read. grant is 1 exactly when the needed right (read, write or execute) is present.
- R8: On a refused data access, the syndrome ORs together 0x08000000 when the page rights lack the needed right, 0x02000000 when the access is a write, and 0x00200000 when the mask rights lack the needed right.
- R9: A refused fetch reports 0x08000000. A fetch with relocation on and segWord[9] set reports exactly 0x10000000, raises segNoExecFault and is refused whatever the page rights are.
- R10: When relocation is off for the access kind (instReloc for fetches, dataReloc otherwise), realAddr is effAddr with bits 63:60 cleared, all three rights are 1, grant is 1 and the syndrome is 0. Otherwise realAddr is 0.
- R11: Whenever grant is 1 the syndrome is 0 and segNoExecFault is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pteWord | input | 64 | Second page table entry word: protection bits, no-execute, guarded, class key |
| segWord | input | 64 | Matching segment attribute word: key flags, no-execute flag |
| probState | input | 1 | 1 for user (problem) state, 0 for supervisor |
| maskReg | input | 64 | Class-key mask register, two bits per key |
| maskEnable | input | 1 | 1 enables class-key masking |
| accType | input | 2 | Access kind: 0 read, 1 write, 2 fetch, 3 read |
| instReloc | input | 1 | Relocation enable for fetches |
| dataReloc | input | 1 | Relocation enable for data accesses |
| effAddr | input | 64 | Effective address of the access |
| realAddr | output | 64 | Real address in bypass, else 0 |
| allowRead | output | 1 | Read right |
| allowWrite | output | 1 | Write right |
| allowExec | output | 1 | Execute right |
| grant | output | 1 | Access allowed |
| segNoExecFault | output | 1 | Fetch refused by segment no-execute |
| syndrome | output | 32 | Fault syndrome bits, 0 on grant |

## Verification
The assertions assume every input holds a settled value when they are evaluated. They also assume that maskReg carries meaningful pairs for all 32 keys, so that the mask bits a check reads are the ones the key selects. The stimulus changes inputs only between samples. It draws every field at random, including access kind 3 and both relocation enables, and it biases the draws so that bypass, segment no-execute, each protection code and each key bit occur often. Directed cases cover the extreme key positions 0 and 31 in the mask, and the protection codes that differ between the two key values.

// File: rtl/pageAccessPkg.sv
package pageAccessPkg;

  localparam int ADDR_W       = 64;
  localparam int WORD_W       = 64;
  localparam int MASK_W       = 64;
  localparam int KEY_W        = 5;
  localparam int SYN_W        = 32;
  localparam int REAL_CLR_BITS = 4;

  // page entry field positions
  localparam int PTE_PP_LO    = 0;
  localparam int PTE_NOEXEC   = 2;
  localparam int PTE_GUARD    = 3;
  localparam int PTE_KEY_LO   = 9;
  localparam int PTE_PP_HI    = 63;

  // segment word field positions
  localparam int SEG_NOEXEC   = 9;
  localparam int SEG_USERKEY  = 10;
  localparam int SEG_SUPKEY   = 11;

  // syndrome values
  localparam logic [SYN_W-1:0] SYN_SEG_NX = 32'h1000_0000;
  localparam logic [SYN_W-1:0] SYN_PROT   = 32'h0800_0000;
  localparam logic [SYN_W-1:0] SYN_STORE  = 32'h0200_0000;
  localparam logic [SYN_W-1:0] SYN_KEY    = 32'h0020_0000;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_ALTRD = 2'd3
  } accKind_e;

  typedef struct packed {
    logic rd;
    logic wr;
    logic ex;
  } rights_t;

  typedef struct packed {
    logic bypass;
    logic segNxFault;
    logic denied;
    logic pageShort;
    logic keyShort;
    logic isStore;
    logic isFetch;
  } strobes_t;

endpackage

// File: rtl/ppRightsDecode.sv
module ppRightsDecode
  import pageAccessPkg::*;
(
  input  logic       keyBit,
  input  logic [2:0] protCode,
  output logic       rdOk,
  output logic       wrOk
);

  always_comb begin
    rdOk = 1'b0;
    wrOk = 1'b0;
    if (!keyBit) begin
      unique case (protCode)
        3'd0, 3'd1, 3'd2: begin rdOk = 1'b1; wrOk = 1'b1; end
        3'd3, 3'd6:       begin rdOk = 1'b1; end
        default:          ;
      endcase
    end else begin
      unique case (protCode)
        3'd2:       begin rdOk = 1'b1; wrOk = 1'b1; end
        3'd1, 3'd3: begin rdOk = 1'b1; end
        default:    ;
      endcase
    end
  end

endmodule

// File: rtl/classKeyRights.sv
module classKeyRights
  import pageAccessPkg::*;
#(
  parameter int MASK_BITS = MASK_W,
  parameter int KEY_BITS  = KEY_W
) (
  input  logic [MASK_BITS-1:0] maskReg,
  input  logic                 maskEnable,
  input  logic [KEY_BITS-1:0]  classKey,
  output logic                 rdOk,
  output logic                 wrOk
);

  localparam int KEYS = 1 << KEY_BITS;

  logic [1:0] pairs [KEYS];

  // key k owns the pair at 2*(KEYS-1-k): key 0 sits at the top of the register
  for (genvar k = 0; k < KEYS; k++) begin : g_pair
    assign pairs[k] = maskReg[2*(KEYS-1-k) +: 2];
  end

  logic [1:0] selPair;
  assign selPair = pairs[classKey];

  assign rdOk = maskEnable ? selPair[0] : 1'b1;
  assign wrOk = maskEnable ? selPair[1] : 1'b1;

endmodule

// File: rtl/pageAccessControl.sv
module pageAccessControl
  import pageAccessPkg::*;
(
  input  logic [1:0] accType,
  input  logic       instReloc,
  input  logic       dataReloc,
  input  logic       segNoExec,
  input  logic       pageLack,
  input  logic       keyLack,
  output strobes_t   strobes
);

  logic isFetch;
  logic relocOn;
  logic nxHit;

  always_comb begin
    isFetch = (accType == ACC_FETCH);
    relocOn = isFetch ? instReloc : dataReloc;
    nxHit   = relocOn && isFetch && segNoExec;

    strobes.bypass     = !relocOn;
    strobes.segNxFault = nxHit;
    strobes.denied     = relocOn && (nxHit || pageLack || keyLack);
    strobes.pageShort  = pageLack;
    strobes.keyShort   = keyLack;
    strobes.isStore    = (accType == ACC_WRITE);
    strobes.isFetch    = isFetch;
  end

endmodule

// File: rtl/pageAccessDatapath.sv
module pageAccessDatapath
  import pageAccessPkg::*;
(
  input  logic [WORD_W-1:0] pteWord,
  input  logic [WORD_W-1:0] segWord,
  input  logic              probState,
  input  logic [MASK_W-1:0] maskReg,
  input  logic              maskEnable,
  input  logic [1:0]        accType,
  input  logic [ADDR_W-1:0] effAddr,
  input  strobes_t          strobes,
  output logic              pageLack,
  output logic              keyLack,
  output logic [ADDR_W-1:0] realAddr,
  output rights_t           rights,
  output logic              grant,
  output logic [SYN_W-1:0]  syndrome
);

  logic       keyBit;
  logic [2:0] protCode;
  logic [KEY_W-1:0] classKey;
  rights_t    pageR;
  rights_t    maskR;
  rights_t    bothR;
  rights_t    need;

  assign keyBit   = probState ? segWord[SEG_USERKEY] : segWord[SEG_SUPKEY];
  assign protCode = {pteWord[PTE_PP_HI], pteWord[PTE_PP_LO +: 2]};
  assign classKey = pteWord[PTE_KEY_LO +: KEY_W];

  ppRightsDecode u_ppDecode (
    .keyBit  (keyBit),
    .protCode(protCode),
    .rdOk    (pageR.rd),
    .wrOk    (pageR.wr)
  );

  assign pageR.ex = !(pteWord[PTE_NOEXEC] || pteWord[PTE_GUARD] || segWord[SEG_NOEXEC]);

  classKeyRights #(.MASK_BITS(MASK_W), .KEY_BITS(KEY_W)) u_keyRights (
    .maskReg   (maskReg),
    .maskEnable(maskEnable),
    .classKey  (classKey),
    .rdOk      (maskR.rd),
    .wrOk      (maskR.wr)
  );

  assign maskR.ex = 1'b1;
  assign bothR    = pageR & maskR;

  always_comb begin
    need = '0;
    unique case (accType)
      ACC_WRITE: need.wr = 1'b1;
      ACC_FETCH: need.ex = 1'b1;
      default:   need.rd = 1'b1;
    endcase
  end

  assign pageLack = |(need & ~pageR);
  assign keyLack  = |(need & ~maskR);

  always_comb begin
    realAddr = '0;
    rights   = bothR;
    syndrome = '0;
    if (strobes.bypass) begin
      realAddr = {{REAL_CLR_BITS{1'b0}}, effAddr[ADDR_W-REAL_CLR_BITS-1:0]};
      rights   = '1;
    end else if (strobes.denied) begin
      if (strobes.segNxFault) begin
        syndrome = SYN_SEG_NX;
      end else if (strobes.isFetch) begin
        syndrome = SYN_PROT;
      end else begin
        if (strobes.pageShort) syndrome = syndrome | SYN_PROT;
        if (strobes.isStore)   syndrome = syndrome | SYN_STORE;
        if (strobes.keyShort)  syndrome = syndrome | SYN_KEY;
      end
    end
  end

  assign grant = !strobes.denied;

endmodule

// File: rtl/pageAccessEval.sv
module pageAccessEval
  import pageAccessPkg::*;
(
  input  logic [63:0] pteWord,
  input  logic [63:0] segWord,
  input  logic        probState,
  input  logic [63:0] maskReg,
  input  logic        maskEnable,
  input  logic [1:0]  accType,
  input  logic        instReloc,
  input  logic        dataReloc,
  input  logic [63:0] effAddr,
  output logic [63:0] realAddr,
  output logic        allowRead,
  output logic        allowWrite,
  output logic        allowExec,
  output logic        grant,
  output logic        segNoExecFault,
  output logic [31:0] syndrome
);

  strobes_t strobes;
  rights_t  rights;
  logic     pageLack;
  logic     keyLack;

  pageAccessControl u_ctrl (
    .accType  (accType),
    .instReloc(instReloc),
    .dataReloc(dataReloc),
    .segNoExec(segWord[SEG_NOEXEC]),
    .pageLack (pageLack),
    .keyLack  (keyLack),
    .strobes  (strobes)
  );

  pageAccessDatapath u_dp (
    .pteWord   (pteWord),
    .segWord   (segWord),
    .probState (probState),
    .maskReg   (maskReg),
    .maskEnable(maskEnable),
    .accType   (accType),
    .effAddr   (effAddr),
    .strobes   (strobes),
    .pageLack  (pageLack),
    .keyLack   (keyLack),
    .realAddr  (realAddr),
    .rights    (rights),
    .grant     (grant),
    .syndrome  (syndrome)
  );

  assign allowRead      = rights.rd;
  assign allowWrite     = rights.wr;
  assign allowExec      = rights.ex;
  assign segNoExecFault = strobes.segNxFault;

endmodule

// File: rtl/pageAccessChecker.sv
module pageAccessChecker (
  input logic [63:0] pteWord,
  input logic [63:0] segWord,
  input logic [63:0] maskReg,
  input logic        maskEnable,
  input logic [1:0]  accType,
  input logic        instReloc,
  input logic        dataReloc,
  input logic [63:0] effAddr,
  input logic [63:0] realAddr,
  input logic        allowRead,
  input logic        allowWrite,
  input logic        allowExec,
  input logic        grant,
  input logic        segNoExecFault,
  input logic [31:0] syndrome
);

  logic isFetchC;
  logic bypassC;
  logic [5:0] pairPos;

  always_comb begin
    isFetchC = (accType == 2'd2);
    bypassC  = isFetchC ? !instReloc : !dataReloc;
    pairPos  = 6'(2 * (31 - int'(pteWord[13:9])));

    // R11: a granted access carries no fault information
    assert_clean_grant_R11: assert (!grant || (syndrome == 32'd0 && !segNoExecFault))
      else $error("grant with syndrome %h", syndrome);

    // R10: bypass gives full rights and the cleared real address
    assert_bypass_full_R10: assert (!bypassC ||
        (grant && allowRead && allowWrite && allowExec && realAddr[63:60] == 4'd0 &&
         realAddr[59:0] == effAddr[59:0]))
      else $error("bypass result wrong");

    // R9: segment no-execute fetch fault
    assert_seg_nx_R9: assert (!segNoExecFault || (!grant && syndrome == 32'h1000_0000 && isFetchC))
      else $error("segment no-execute fault inconsistent");

    // R5: execute only when none of the three blocking bits is set
    assert_exec_block_R5: assert (bypassC || !allowExec || !(pteWord[2] || pteWord[3] || segWord[9]))
      else $error("exec allowed despite blocking bit");

    // R6: mask gates write and read
    assert_mask_gate_R6: assert (bypassC || !maskEnable ||
        ((!allowWrite || maskReg[pairPos + 6'd1]) && (!allowRead || maskReg[pairPos])))
      else $error("right allowed against class mask");

    // R8: store marker follows the access kind on data refusals
    assert_store_mark_R8: assert (grant || isFetchC || (syndrome[25] == (accType == 2'd1)))
      else $error("store marker wrong");
  end

endmodule

bind pageAccessEval pageAccessChecker u_checker (
  .pteWord       (pteWord),
  .segWord       (segWord),
  .maskReg       (maskReg),
  .maskEnable    (maskEnable),
  .accType       (accType),
  .instReloc     (instReloc),
  .dataReloc     (dataReloc),
  .effAddr       (effAddr),
  .realAddr      (realAddr),
  .allowRead     (allowRead),
  .allowWrite    (allowWrite),
  .allowExec     (allowExec),
  .grant         (grant),
  .segNoExecFault(segNoExecFault),
  .syndrome      (syndrome)
);

// File: tb/pageAccessEval_bench.sv
module pageAccessEval_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic [63:0] pteWord, segWord, maskReg, effAddr;
  logic        probState, maskEnable, instReloc, dataReloc;
  logic [1:0]  accType;
  logic [63:0] realAddr;
  logic        allowRead, allowWrite, allowExec, grant, segNoExecFault;
  logic [31:0] syndrome;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit finished = 0;

  pageAccessEval u_pageAccessEval (
    .pteWord(pteWord), .segWord(segWord), .probState(probState), .maskReg(maskReg),
    .maskEnable(maskEnable), .accType(accType), .instReloc(instReloc),
    .dataReloc(dataReloc), .effAddr(effAddr), .realAddr(realAddr),
    .allowRead(allowRead), .allowWrite(allowWrite), .allowExec(allowExec),
    .grant(grant), .segNoExecFault(segNoExecFault), .syndrome(syndrome)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // expected-value model built from the requirements
  logic [63:0] eRa;
  logic [2:0]  eRwx;
  logic        eGrant, eSnx;
  logic [31:0] eSyn;

  task automatic model();
    logic k, pr, pw, px, kr, kw, r, w, x, need, pLack, kLack, fetch, reloc;
    logic [2:0] code;
    int sh;
    k    = probState ? segWord[10] : segWord[11];          // R1
    code = {pteWord[63], pteWord[1:0]};                    // R2
    pr = 0; pw = 0;
    if (!k) begin                                          // R3
      if (code <= 3'd2) begin pr = 1; pw = 1; end
      else if (code == 3'd3 || code == 3'd6) pr = 1;
    end else begin                                         // R4
      if (code == 3'd2) begin pr = 1; pw = 1; end
      else if (code == 3'd1 || code == 3'd3) pr = 1;
    end
    px = !(pteWord[2] | pteWord[3] | segWord[9]);          // R5
    if (maskEnable) begin                                  // R6
      sh = 2 * (31 - int'(pteWord[13:9]));
      kr = maskReg[sh]; kw = maskReg[sh+1];
    end else begin kr = 1; kw = 1; end
    r = pr & kr; w = pw & kw; x = px;
    fetch = (accType == 2'd2);
    reloc = fetch ? instReloc : dataReloc;
    if (accType == 2'd1) begin need = w; pLack = !pw; kLack = !kw; end
    else if (fetch) begin need = x; pLack = !px; kLack = 0; end
    else begin need = r; pLack = !pr; kLack = !kr; end
    eRa = 64'd0; eSyn = 32'd0; eSnx = 0;
    if (!reloc) begin                                      // R10
      eRa = {4'd0, effAddr[59:0]}; eRwx = 3'b111; eGrant = 1;
    end else begin
      eRwx = {r, w, x};
      if (fetch && segWord[9]) begin                       // R9
        eSnx = 1; eGrant = 0; eSyn = 32'h1000_0000;
      end else begin
        eGrant = need;                                     // R7
        if (!need) begin
          if (fetch) eSyn = 32'h0800_0000;
          else begin                                       // R8
            if (pLack) eSyn |= 32'h0800_0000;
            if (accType == 2'd1) eSyn |= 32'h0200_0000;
            if (kLack) eSyn |= 32'h0020_0000;
          end
        end
      end
    end
  endtask

  task automatic check(input string req, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic applyAndCompare(input string req);
    @(posedge clk);
    #2;
    model();
    check(req, "rights", {61'd0, allowRead, allowWrite, allowExec}, {61'd0, eRwx});
    check(req, "grant", {63'd0, grant}, {63'd0, eGrant});
    check(req, "syndrome", {32'd0, syndrome}, {32'd0, eSyn});
    check(req, "segNx", {63'd0, segNoExecFault}, {63'd0, eSnx});
    check(req, "realAddr", realAddr, eRa);
  endtask

  task automatic setBase();
    pteWord = 64'd0; segWord = 64'd0; maskReg = 64'd0; effAddr = 64'd0;
    probState = 0; maskEnable = 0; accType = 2'd0; instReloc = 1; dataReloc = 1;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    setBase();
    instReloc = 0; dataReloc = 0;
    repeat (3) @(posedge clk);
    rstN = 1;
    @(negedge clk);
    // reset / idle state: all zero inputs, relocation off
    check("R10", "idle grant", {63'd0, grant}, 64'd1);
    check("R10", "idle rights", {61'd0, allowRead, allowWrite, allowExec}, 64'd7);

    // R10: data bypass clears top bits
    @(negedge clk); setBase(); dataReloc = 0; accType = 2'd1; effAddr = '1;
    applyAndCompare("R10");
    check("R10", "bypass addr", realAddr, 64'h0FFF_FFFF_FFFF_FFFF);

    // R10: fetch bypass ignores segment no-execute
    @(negedge clk); setBase(); instReloc = 0; accType = 2'd2; segWord[9] = 1;
    effAddr = 64'hF123_4567_89AB_CDEF;
    applyAndCompare("R10");
    check("R10", "fetch bypass grant", {63'd0, grant}, 64'd1);

    // R9: segment no-execute fetch
    @(negedge clk); setBase(); accType = 2'd2; segWord[9] = 1;
    applyAndCompare("R9");
    check("R9", "seg nx syndrome", {32'd0, syndrome}, 64'h1000_0000);

    // R3: key 0 code 3 write refused
    @(negedge clk); setBase(); pteWord[1:0] = 2'd3; accType = 2'd1;
    applyAndCompare("R3");
    check("R3", "ro write syndrome", {32'd0, syndrome}, 64'h0A00_0000);

    // R4: key 1 code 0 read refused (user key)
    @(negedge clk); setBase(); probState = 1; segWord[10] = 1;
    applyAndCompare("R4");
    check("R4", "key1 code0 grant", {63'd0, grant}, 64'd0);

    // R1: user state ignores supervisor key
    @(negedge clk); setBase(); probState = 1; segWord[11] = 1; accType = 2'd1;
    applyAndCompare("R1");
    check("R1", "user key 0 write", {63'd0, grant}, 64'd1);

    // R2: code 6 from the high bit
    @(negedge clk); setBase(); pteWord[63] = 1; pteWord[1:0] = 2'd2; accType = 2'd1;
    applyAndCompare("R2");
    check("R2", "code6 write", {63'd0, grant}, 64'd0);

    // R6: key 31 uses bits 1:0, read only
    @(negedge clk); setBase(); maskEnable = 1; pteWord[13:9] = 5'd31; maskReg = 64'h1;
    accType = 2'd1;
    applyAndCompare("R6");
    check("R6", "key31 write syndrome", {32'd0, syndrome}, 64'h0220_0000);

    // R6: key 0 uses bits 63:62, write only
    @(negedge clk); setBase(); maskEnable = 1; maskReg = 64'h8000_0000_0000_0000;
    applyAndCompare("R6");
    check("R6", "key0 read syndrome", {32'd0, syndrome}, 64'h0020_0000);

    // R5: guarded page refuses fetch
    @(negedge clk); setBase(); pteWord[3] = 1; accType = 2'd2;
    applyAndCompare("R5");
    check("R5", "guarded fetch syndrome", {32'd0, syndrome}, 64'h0800_0000);

    // R6: mask never restricts execute
    @(negedge clk); setBase(); maskEnable = 1; accType = 2'd2; pteWord[1:0] = 2'd2;
    applyAndCompare("R6");
    check("R6", "exec through zero mask", {63'd0, grant}, 64'd1);

    // R7: access kind 3 behaves as read
    @(negedge clk); setBase(); probState = 1; segWord[10] = 1; pteWord[1:0] = 2'd1;
    accType = 2'd3;
    applyAndCompare("R7");
    check("R7", "kind3 read grant", {63'd0, grant}, 64'd1);

    // random mix: R8 and R11 checked through the model on every vector
    for (int i = 0; i < 1500; i++) begin
      @(negedge clk);
      pteWord    = {$urandom, $urandom};
      segWord    = {$urandom, $urandom};
      maskReg    = {$urandom, $urandom};
      effAddr    = {$urandom, $urandom};
      probState  = 1'($urandom);
      maskEnable = 1'($urandom);
      accType    = 2'($urandom);
      instReloc  = ($urandom % 5) != 0;
      dataReloc  = ($urandom % 5) != 0;
      if ($urandom % 2) begin pteWord[2] = 0; pteWord[3] = 0; end
      if ($urandom % 2) segWord[9] = 0;
      applyAndCompare(i % 2 ? "R8" : "R11");
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule